// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block pulls a configuration image out of a small serial EEPROM of the three-wire, opcode-driven kind. It acts on its own when reset is released. It drives chip select, shift clock and data toward the device, and it samples the data line coming back. Before reading anything else, it finds out whether the part holds 64 or 256 sixteen-bit words. It then reads every word in ascending address order and keeps a 16-bit running sum of them.

When the last word is in, the block raises a done flag. Alongside it stands an error flag, which tells whether the sum matched the fixed signature 0xBABA. The block also publishes three fields taken from fixed words of the image: a 48-bit station address, a 6-bit PHY type and a 5-bit PHY management address. A pulse on the start input throws away any work in progress and runs the whole sequence again.

Every serial phase is stretched to `PHASE_CYCLES` core clocks. The default is 200, which gives about 2 µs per phase on a 100 MHz clock. That is twice the 1 µs minimum that such parts need.

Top module: `ee_cfg_loader`

## Requirements
- R1: Chip select is high for the whole of a transaction, and the shift clock is never high while chip select is low. A transaction opens with one clock pulse during which data-out is 0. It closes by lowering the clock for one phase, and then chip select.
- R2: Each transaction shifts 28 bits, with bit 27 of the command going first. The loader sets each bit on `ee_di_o` while the clock is low and holds it steady while the clock is high. It samples `ee_do_i` at the end of the high phase and shifts the sample into the low end of a 28-bit capture. A transaction therefore has 29 rising clock edges.
- R3: Every clock-high phase and every clock-low phase inside a transaction lasts `PHASE_CYCLES` core clocks.
- R4: The first transaction is a probe. Its bits are 0, 1, 1, 0, then eight 0 address bits, then sixteen 0 bits. If capture bits 27 down to 17 are all ones, the part is taken as 256 words with 8-bit addresses; otherwise it is taken as 64 words with 6-bit addresses. The probe is followed by exactly 256 or 64 read transactions.
- R5: The read transactions use addresses 0, 1, 2 and so on up to the last word, and each one carries the read opcode bits 1,0 right after the start bit. In 8-bit mode the command is 0,1,1,0, then the address MSB first, then sixteen 0 bits. In 6-bit mode it is 0,0,0,1,1,0, then the 6-bit address, then sixteen 0 bits. The word read is capture bits 15:0.
- R6: Chip select stays low for at least `PHASE_CYCLES` core clocks between two transactions, and also after a transaction that was cut short.
- R7: All words are added modulo 2^16. When done rises, `chk_err_o` is 1 if the total differs from 0xBABA and 0 if it equals it. `chk_err_o` is never 1 while done is low.
- R8: `station_addr_o[15:0]` holds word 0, `[31:16]` holds word 1 and `[47:32]` holds word 2. Octet n of the address is thus `station_addr_o[8n+7:8n]`, the low byte of each word coming first.
- R9: `phy_type_o` is bits 13:8 of word 6 and `phy_addr_o` is bits 4:0 of word 6. The other bits of that word have no effect on these outputs.
- R10: `done_o` is 0 while a load runs. It becomes 1 after the last word and stays 1 until the next start. A start pulse, even in the middle of a transaction, clears done and the error flag on the following cycle and begins the sequence again from the probe.
- R11: While reset is held, chip select, clock, data-out, done, error and the station address are all 0. Once reset is released, the probe starts without any start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that restarts the load |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM shift clock |
| ee_di_o | output | 1 | Serial data toward the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| station_addr_o | output | 48 | Station address from words 0 to 2 |
| phy_type_o | output | 6 | PHY type from word 6 |
| phy_addr_o | output | 5 | PHY management address from word 6 |
| done_o | output | 1 | Load complete |
| chk_err_o | output | 1 | Image sum differs from the signature |

## Verification
The bench builds the loader with `PHASE_CYCLES` = 2. At that setting a complete 256-word load, probe included, fits in roughly 31,000 core clocks. This leaves room in one run for both device sizes, a good image and a corrupt one, and a restart that lands in the middle of a transaction. With such short phases the minimum-phase and chip-select-gap limits are also tight enough that an off-by-one in the phase counter or in the abort path shows up as a violation.

// File: rtl/ee_cfg_pkg.sv
package ee_cfg_pkg;

    // Serial frame: one leading pad/start area, opcode, address, 16 data bits.
    localparam int XFER_BITS   = 28;
    localparam int WORD_BITS   = 16;
    localparam logic [2:0] RD_OP = 3'b110;   // start bit + read opcode

    // Size probe window inside the 28-bit capture.
    localparam int DET_HI      = 27;
    localparam int DET_LO      = 17;
    localparam int DET_BITS    = DET_HI - DET_LO + 1;

    // Device geometries.
    localparam int ABITS_SMALL = 6;
    localparam int ABITS_BIG   = 8;
    localparam int WORDS_SMALL = 1 << ABITS_SMALL;
    localparam int WORDS_BIG   = 1 << ABITS_BIG;
    localparam int WIDX_W      = ABITS_BIG;

    // Image layout.
    localparam int MAC_WORDS   = 3;
    localparam int MAC_BITS    = MAC_WORDS * WORD_BITS;
    localparam int PHY_WORD    = 6;
    localparam int PTYPE_W     = 6;
    localparam int PTYPE_LSB   = 8;
    localparam int PADDR_W     = 5;

    localparam logic [WORD_BITS-1:0] SUM_SIGNATURE = 16'hBABA;

    typedef enum logic [2:0] {
        X_IDLE,
        X_PRE_LO,
        X_PRE_HI,
        X_BIT_LO,
        X_BIT_HI,
        X_END_SK,
        X_END_CS
    } xfer_st_e;

    typedef enum logic [2:0] {
        L_ARM,
        L_DET,
        L_ISSUE,
        L_WAIT,
        L_DONE
    } ld_st_e;

endpackage

// File: rtl/ee_phase_timer.sv
module ee_phase_timer #(
    parameter int PHASE_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int TW = $clog2(PHASE_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(PHASE_CYCLES - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/ee_serial_xfer.sv
module ee_serial_xfer
    import ee_cfg_pkg::*;
#(
    parameter int NBITS = XFER_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_i,
    input  logic                 abort_i,
    input  logic [NBITS-1:0]     cmd_i,
    input  logic                 tick_i,
    input  logic                 do_i,
    output logic                 tmr_clr_o,
    output logic                 busy_o,
    output logic                 fin_o,
    output logic [DET_BITS-1:0]  head_o,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 sk_o,
    output logic                 cs_o,
    output logic                 di_o
);
    localparam int CW = $clog2(NBITS);
    localparam logic [CW-1:0] LAST_BIT = CW'(NBITS - 1);

    typedef struct packed {
        xfer_st_e          st;
        logic              live;
        logic [NBITS-1:0]  sh;
        logic [NBITS-1:0]  rx;
        logic [CW-1:0]     cnt;
        logic              sk;
        logic              cs;
        logic              di;
    } xfer_s;

    xfer_s x_d, x_q;

    always_comb begin
        x_d       = x_q;
        fin_o     = 1'b0;
        tmr_clr_o = 1'b0;

        if (abort_i) begin
            // Cut the frame: drop clock and select together, keep select low one phase.
            if (x_q.st != X_IDLE) begin
                x_d.st    = X_END_CS;
                x_d.live  = 1'b0;
                tmr_clr_o = 1'b1;
            end
        end else begin
            case (x_q.st)
                X_IDLE: begin
                    if (go_i) begin
                        x_d.st    = X_PRE_LO;
                        x_d.live  = 1'b1;
                        x_d.sh    = cmd_i;
                        x_d.rx    = '0;
                        x_d.cnt   = '0;
                        tmr_clr_o = 1'b1;
                    end
                end
                X_PRE_LO: if (tick_i) x_d.st = X_PRE_HI;
                X_PRE_HI: if (tick_i) x_d.st = X_BIT_LO;
                X_BIT_LO: if (tick_i) x_d.st = X_BIT_HI;
                X_BIT_HI: begin
                    if (tick_i) begin
                        x_d.rx = {x_q.rx[NBITS-2:0], do_i};
                        if (x_q.cnt == LAST_BIT) begin
                            x_d.st = X_END_SK;
                        end else begin
                            x_d.sh  = x_q.sh << 1;
                            x_d.cnt = x_q.cnt + 1'b1;
                            x_d.st  = X_BIT_LO;
                        end
                    end
                end
                X_END_SK: if (tick_i) x_d.st = X_END_CS;
                X_END_CS: begin
                    if (tick_i) begin
                        x_d.st   = X_IDLE;
                        x_d.live = 1'b0;
                        fin_o    = x_q.live;
                    end
                end
                default: x_d.st = X_IDLE;
            endcase
        end

        // Pin levels are registered from the next state.
        x_d.cs = (x_d.st inside {X_PRE_LO, X_PRE_HI, X_BIT_LO, X_BIT_HI, X_END_SK});
        x_d.sk = (x_d.st inside {X_PRE_HI, X_BIT_HI});
        x_d.di = (x_d.st inside {X_BIT_LO, X_BIT_HI}) & x_d.sh[NBITS-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '{st: X_IDLE, live: 1'b0, sh: '0, rx: '0, cnt: '0,
                     sk: 1'b0, cs: 1'b0, di: 1'b0};
        end else begin
            x_q <= x_d;
        end
    end

    assign busy_o = (x_q.st != X_IDLE);
    assign head_o = x_q.rx[DET_HI:DET_LO];
    assign word_o = x_q.rx[WORD_BITS-1:0];
    assign sk_o   = x_q.sk;
    assign cs_o   = x_q.cs;
    assign di_o   = x_q.di;

endmodule

// File: rtl/ee_cfg_loader.sv
module ee_cfg_loader
    import ee_cfg_pkg::*;
#(
    parameter int PHASE_CYCLES = 200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    output logic                 ee_cs_o,
    output logic                 ee_sk_o,
    output logic                 ee_di_o,
    input  logic                 ee_do_i,
    output logic [MAC_BITS-1:0]  station_addr_o,
    output logic [PTYPE_W-1:0]   phy_type_o,
    output logic [PADDR_W-1:0]   phy_addr_o,
    output logic                 done_o,
    output logic                 chk_err_o
);
    localparam int NB = XFER_BITS;
    localparam logic [WIDX_W-1:0] LAST_BIG   = WIDX_W'(WORDS_BIG - 1);
    localparam logic [WIDX_W-1:0] LAST_SMALL = WIDX_W'(WORDS_SMALL - 1);

    typedef struct packed {
        ld_st_e               st;
        logic                 big;
        logic [WIDX_W-1:0]    widx;
        logic [WORD_BITS-1:0] sum;
        logic [MAC_BITS-1:0]  mac;
        logic [PTYPE_W-1:0]   ptype;
        logic [PADDR_W-1:0]   paddr;
        logic                 done;
        logic                 err;
    } ld_s;

    ld_s l_d, l_q;

    logic                 go, busy, fin, tick, tmr_clr;
    logic [NB-1:0]        cmd;
    logic [DET_BITS-1:0]  head;
    logic [WORD_BITS-1:0] word;
    logic [WORD_BITS-1:0] sum_nx;
    logic                 last_word;

    function automatic logic [NB-1:0] read_cmd(input logic big, input logic [WIDX_W-1:0] a);
        if (big) begin
            return {{(NB-3-ABITS_BIG-WORD_BITS){1'b0}}, RD_OP,
                    a[ABITS_BIG-1:0], {WORD_BITS{1'b0}}};
        end
        return {{(NB-3-ABITS_SMALL-WORD_BITS){1'b0}}, RD_OP,
                a[ABITS_SMALL-1:0], {WORD_BITS{1'b0}}};
    endfunction

    ee_phase_timer #(
        .PHASE_CYCLES(PHASE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .tick_o (tick)
    );

    ee_serial_xfer #(
        .NBITS(NB)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .abort_i   (start_i),
        .cmd_i     (cmd),
        .tick_i    (tick),
        .do_i      (ee_do_i),
        .tmr_clr_o (tmr_clr),
        .busy_o    (busy),
        .fin_o     (fin),
        .head_o    (head),
        .word_o    (word),
        .sk_o      (ee_sk_o),
        .cs_o      (ee_cs_o),
        .di_o      (ee_di_o)
    );

    assign sum_nx    = l_q.sum + word;
    assign last_word = l_q.big ? (l_q.widx == LAST_BIG) : (l_q.widx == LAST_SMALL);

    always_comb begin
        l_d = l_q;
        go  = 1'b0;
        cmd = '0;

        if (start_i) begin
            l_d.st   = L_ARM;
            l_d.done = 1'b0;
            l_d.err  = 1'b0;
            l_d.sum  = '0;
            l_d.widx = '0;
        end else begin
            case (l_q.st)
                L_ARM: begin
                    if (!busy) begin
                        go     = 1'b1;
                        cmd    = read_cmd(1'b1, '0);
                        l_d.st = L_DET;
                    end
                end
                L_DET: begin
                    if (fin) begin
                        l_d.big  = &head;
                        l_d.widx = '0;
                        l_d.st   = L_ISSUE;
                    end
                end
                L_ISSUE: begin
                    go     = 1'b1;
                    cmd    = read_cmd(l_q.big, l_q.widx);
                    l_d.st = L_WAIT;
                end
                L_WAIT: begin
                    if (fin) begin
                        l_d.sum = sum_nx;
                        for (int k = 0; k < MAC_WORDS; k++) begin
                            if (l_q.widx == WIDX_W'(k)) begin
                                l_d.mac[k*WORD_BITS +: WORD_BITS] = word;
                            end
                        end
                        if (l_q.widx == WIDX_W'(PHY_WORD)) begin
                            l_d.ptype = word[PTYPE_LSB +: PTYPE_W];
                            l_d.paddr = word[PADDR_W-1:0];
                        end
                        if (last_word) begin
                            l_d.st   = L_DONE;
                            l_d.done = 1'b1;
                            l_d.err  = (sum_nx != SUM_SIGNATURE);
                        end else begin
                            l_d.widx = l_q.widx + 1'b1;
                            l_d.st   = L_ISSUE;
                        end
                    end
                end
                L_DONE: l_d.st = L_DONE;
                default: l_d.st = L_ARM;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '{st: L_ARM, big: 1'b0, widx: '0, sum: '0, mac: '0,
                     ptype: '0, paddr: '0, done: 1'b0, err: 1'b0};
        end else begin
            l_q <= l_d;
        end
    end

    assign station_addr_o = l_q.mac;
    assign phy_type_o     = l_q.ptype;
    assign phy_addr_o     = l_q.paddr;
    assign done_o         = l_q.done;
    assign chk_err_o      = l_q.err;

endmodule

// File: rtl/ee_cfg_loader_chk.sv
module ee_cfg_loader_chk #(
    parameter int PHASE_CYCLES = 200
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic cs,
    input logic sk,
    input logic di,
    input logic done,
    input logic err
);
    localparam int CNT_W = $clog2(PHASE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PHASE_CYCLES);

    logic [CNT_W-1:0] hi_cnt, lo_cnt;
    logic             seen_fall, cs_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt    <= '0;
            lo_cnt    <= '0;
            seen_fall <= 1'b0;
            cs_prev   <= 1'b0;
        end else begin
            cs_prev <= cs;
            if (cs_prev && !cs) seen_fall <= 1'b1;
            if (sk) hi_cnt <= (hi_cnt == CNT_MAX) ? hi_cnt : hi_cnt + 1'b1;
            else    hi_cnt <= '0;
            if (!cs) lo_cnt <= (lo_cnt == CNT_MAX) ? lo_cnt : lo_cnt + 1'b1;
            else     lo_cnt <= '0;
        end
    end

    p_sk_needs_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !sk);

    p_di_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sk && $past(sk)) |-> $stable(di));

    p_sk_high_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sk) && cs) |-> (hi_cnt >= CNT_MAX));

    p_cs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs) && seen_fall) |-> (lo_cnt >= CNT_MAX));

    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_i) |=> done);

    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done && !err));

endmodule

bind ee_cfg_loader ee_cfg_loader_chk #(
    .PHASE_CYCLES(PHASE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cs      (ee_cs_o),
    .sk      (ee_sk_o),
    .di      (ee_di_o),
    .done    (done_o),
    .err     (chk_err_o)
);

// File: tb/ee_cfg_loader_bench.sv
`timescale 1ns/1ps
module ee_cfg_loader_bench;
    localparam int P = 2;
    localparam logic [15:0] SIG = 16'hBABA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ee_cs, ee_sk, ee_di, ee_do;
    logic [47:0] mac;
    logic [5:0]  ptype;
    logic [4:0]  paddr;
    logic done, err;

    always #2.5 clk = ~clk;

    ee_cfg_loader #(.PHASE_CYCLES(P)) u_ee_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(ee_do),
        .station_addr_o(mac), .phy_type_o(ptype), .phy_addr_o(paddr),
        .done_o(done), .chk_err_o(err)
    );

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [0:255];
    int   mabits = 8;
    logic mdo = 1'b1;
    int   mph = 0, mcnt = 0, midx = 0;
    logic [1:0] mop;
    logic [7:0] maddr;
    int   rd_seen = 0, addr_err = 0, op_err = 0;

    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            mph = 0;
            mdo = 1'b1;
        end else begin
            case (mph)
                0: if (ee_di) begin mph = 1; mcnt = 0; end
                1: begin
                    mop = {mop[0], ee_di};
                    mcnt++;
                    if (mcnt == 2) begin mph = 2; mcnt = 0; maddr = '0; end
                end
                2: begin
                    maddr = {maddr[6:0], ee_di};
                    mcnt++;
                    if (mcnt == mabits) begin
                        mph = 3; mdo = 1'b0; midx = 15;
                        if (int'(maddr) != ((rd_seen == 0) ? 0 : rd_seen - 1)) addr_err++;
                        if (mop != 2'b10) op_err++;
                        rd_seen++;
                    end
                end
                3: begin
                    mdo = mem[maddr][midx];
                    if (midx == 0) mph = 4; else midx--;
                end
                default: mdo = 1'b1;
            endcase
        end
    end
    assign ee_do = mdo;

    // ---------------- pin monitor ----------------
    logic pcs = 0, psk = 0, pdi = 0;
    int txn = 0, skn = 0, bad_len = 0, frame_bad = 0, di_bad = 0;
    int hi_len = 0, lo_len = 0, min_hi = 1000000, min_gap = 1000000;
    bit seen_fall = 0, abort_ok = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ee_cs && !pcs) begin
                txn++; skn = 0;
                if (seen_fall && lo_len < min_gap) min_gap = lo_len;
            end
            if (ee_sk && !psk) skn++;
            if (!ee_sk && psk && ee_cs && hi_len < min_hi) min_hi = hi_len;
            if (!ee_cs && pcs) begin
                seen_fall = 1;
                if (abort_ok) abort_ok = 0;
                else begin
                    if (skn != 29) bad_len++;
                    if (psk) frame_bad++;
                end
            end
            if (ee_sk && psk && ee_di != pdi) di_bad++;
            if (ee_sk && !ee_cs) frame_bad++;
            hi_len = ee_sk ? hi_len + 1 : 0;
            lo_len = ee_cs ? 0 : lo_len + 1;
        end
        pcs = ee_cs; psk = ee_sk; pdi = ee_di;
    end

    // ---------------- bookkeeping ----------------
    int n_tests = 0, n_fail = 0, cyc = 0;
    logic [47:0] exp_mac;
    logic [5:0]  exp_pt;
    logic [4:0]  exp_pa;
    logic        exp_err;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 195000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got cycle %0d expected below %0d", cyc, 195000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill_image(input int abits, input int seed, input bit good);
        int n;
        logic [15:0] s;
        n = (abits == 8) ? 256 : 64;
        s = '0;
        for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503 + seed * 977) ^ (i << 7));
        mem[6] = {2'b11, 6'(seed + 3), 3'b101, 5'(seed + 9)};
        for (int i = 0; i < n - 1; i++) s = s + mem[i];
        mem[n-1] = SIG - s + (good ? 16'd0 : 16'd1);
        mabits  = abits;
        exp_mac = {mem[2], mem[1], mem[0]};
        exp_pt  = 6'(seed + 3);
        exp_pa  = 5'(seed + 9);
        exp_err = !good;
    endtask

    task automatic mon_clear();
        txn = 0; bad_len = 0; frame_bad = 0; di_bad = 0;
        min_hi = 1000000; min_gap = 1000000; seen_fall = 0;
        rd_seen = 0; addr_err = 0; op_err = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done(input int limit, output bit ok);
        ok = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
    endtask

    task automatic check_result(input string tag, input int exp_txn);
        check(exp_err == err, "R7", {tag, " checksum flag"}, 64'(err), 64'(exp_err));
        check(mac == exp_mac, "R8", {tag, " station address"}, 64'(mac), 64'(exp_mac));
        check(ptype == exp_pt && paddr == exp_pa, "R9", {tag, " phy fields"},
              64'({ptype, paddr}), 64'({exp_pt, exp_pa}));
        check(txn == exp_txn, "R4", {tag, " transaction count"}, 64'(txn), 64'(exp_txn));
        check(addr_err == 0 && op_err == 0 && rd_seen == exp_txn, "R5", {tag, " read addresses/opcode"},
              64'({addr_err, op_err}), 64'(0));
        check(min_gap >= P, "R6", {tag, " chip select gap"}, 64'(min_gap), 64'(P));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        repeat (4) @(negedge clk);
        check(!ee_cs && !ee_sk && !ee_di, "R11", "pins in reset", 64'({ee_cs, ee_sk, ee_di}), 64'(0));
        check(!done && !err && mac == '0, "R11", "outputs in reset", 64'({done, err, mac}), 64'(0));
        @(negedge clk) rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(ee_cs, "R11", "probe starts after reset", 64'(ee_cs), 64'(1));
    endtask

    task automatic t_big_good();
        bit ok;
        int t0;
        wait_done(60000, ok);
        check(ok, "R10", "256-word load finished", 64'(ok), 64'(1));
        check_result("256 good", 257);
        check(bad_len == 0, "R2", "29 clocks per transaction", 64'(bad_len), 64'(0));
        check(di_bad == 0, "R2", "data held during clock high", 64'(di_bad), 64'(0));
        check(min_hi >= P, "R3", "clock high phase length", 64'(min_hi), 64'(P));
        check(frame_bad == 0, "R1", "clock only inside select", 64'(frame_bad), 64'(0));
        t0 = txn;
        repeat (40) @(negedge clk);
        check(done && txn == t0 && !ee_cs, "R10", "done held and bus idle", 64'({done, ee_cs}), 64'(2));
    endtask

    task automatic t_small_bad();
        bit ok;
        fill_image(6, 5, 1'b0);
        mon_clear();
        pulse_start();
        check(!done && !err, "R10", "start clears flags", 64'({done, err}), 64'(0));
        wait_done(30000, ok);
        check(ok, "R10", "64-word load finished", 64'(ok), 64'(1));
        check_result("64 bad", 65);
        check(bad_len == 0 && frame_bad == 0, "R1", "64-word framing", 64'({bad_len, frame_bad}), 64'(0));
    endtask

    task automatic t_restart_mid();
        bit ok;
        fill_image(6, 11, 1'b1);
        mon_clear();
        pulse_start();
        repeat (20 * 60 * P + 7) @(negedge clk);
        check(!done && ee_cs, "R10", "done low mid-load", 64'({done, ee_cs}), 64'(1));
        mon_clear();
        abort_ok = 1;
        pulse_start();
        wait_done(30000, ok);
        check(ok, "R10", "restarted load finished", 64'(ok), 64'(1));
        check_result("restart", 65);
        check(min_hi >= P, "R3", "clock high after restart", 64'(min_hi), 64'(P));
    endtask

    initial begin
        fill_image(8, 1, 1'b1);
        t_reset_state();
        t_big_good();
        t_small_bad();
        t_restart_mid();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule